// File: doc/BRIEF.md
# Up/Down Counter with Hold, Halt and Selectable Reload

This block is a loadable up/down counter. Each rising clock edge moves the count one step in the direction given by `cnt_up`, unless `hold` freezes it or `halt` stops it. While stopped, the counter is kept at a start word. That start word is one of three parallel data buses: a fixed design value, a converter result or a value written over a serial port. `src_sel` picks the bus. When `halt` is released, counting resumes from that start word.

When the count steps past its maximum while counting up, or past zero while counting down, a wrap takes place. `reload_mode` chooses what the counter receives on a wrap: the currently selected start word, or zero. Every wrap raises `wrap_pulse` for exactly one clock. The count width is the parameter `W`, normally 8 or 16.

Top module: `updn_hold_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and `wrap_pulse` is 0.
- R2: On the first clock edge after reset is released, and on every edge while `halt` is high, `count` takes the selected start word. The encoding of `src_sel` is: 2'b00 selects `const_word`, 2'b01 selects `adc_word`, 2'b10 and 2'b11 select `spi_word`.
- R3: When `halt` and `hold` are low and `cnt_up` is high, an edge adds one to `count` if `count` is below 2^W-1.
- R4: When `halt` and `hold` are low and `cnt_up` is low, an edge subtracts one from `count` if `count` is above 0.
- R5: When `halt` is low and `hold` is high, `count` keeps its value whatever `cnt_up` is, and `wrap_pulse` stays low.
- R6: `halt` overrides `hold`. After `halt` falls, counting continues from the start word that was loaded.
- R7: When counting up from 2^W-1, the next value is the selected start word if `reload_mode` is 1, and 0 if `reload_mode` is 0.
- R8: When counting down from 0, the next value is the selected start word if `reload_mode` is 1, and 0 if `reload_mode` is 0.
- R9: `wrap_pulse` is high for the one cycle that follows an edge at which a wrap of R7 or R8 happened. In every other cycle it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_up | input | 1 | Direction: 1 counts up, 0 counts down |
| hold | input | 1 | Freezes the count while high |
| halt | input | 1 | Stops the counter and keeps it at the start word |
| src_sel | input | 2 | Selects the start word bus |
| reload_mode | input | 1 | Wrap target: 1 is the start word, 0 is zero |
| const_word | input | W | Fixed design start value |
| adc_word | input | W | Converter result start value |
| spi_word | input | W | Serially written start value |
| count | output | W | Current count |
| wrap_pulse | output | 1 | One-cycle pulse after a wrap |

## Verification
The bench uses a 4-bit counter. Every start value is loaded from every `src_sel` code, and each load is followed by a long upward run and a long downward run. Each run passes at least one wrap, and the bench alternates the two reload settings. This separates the two wrap targets and the three buses, including the duplicated code 2'b11.

Periodic `hold` cycles are mixed into the runs. These show that a frozen count moves neither way and raises no pulse. The start words are changed while the counter runs, so a reload is shown to take the word present at the wrap edge. A halt asserted during a hold checks priority, and the count after halt release checks where counting restarts.

// File: rtl/updn_hold_counter.sv
module updn_hold_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_up,
  input  logic         hold,
  input  logic         halt,
  input  logic [1:0]   src_sel,
  input  logic         reload_mode,
  input  logic [W-1:0] const_word,
  input  logic [W-1:0] adc_word,
  input  logic [W-1:0] spi_word,
  output logic [W-1:0] count,
  output logic         wrap_pulse
);
  localparam logic [W-1:0] TOP = '1;

  logic         primed;
  logic [W-1:0] src_word;
  logic         at_edge;

  assign src_word = (src_sel == 2'd0) ? const_word :
                    (src_sel == 2'd1) ? adc_word : spi_word;
  assign at_edge  = cnt_up ? (count == TOP) : (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count      <= '0;
      wrap_pulse <= 1'b0;
      primed     <= 1'b0;
    end else if (halt || !primed) begin
      count      <= src_word;
      wrap_pulse <= 1'b0;
      primed     <= 1'b1;
    end else if (hold) begin
      wrap_pulse <= 1'b0;
    end else if (at_edge) begin
      count      <= reload_mode ? src_word : '0;
      wrap_pulse <= 1'b1;
    end else begin
      count      <= cnt_up ? count + 1'b1 : count - 1'b1;
      wrap_pulse <= 1'b0;
    end
  end

  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !halt && !hold && cnt_up && count != TOP) |=> (count == $past(count) + 1'b1));

  // R4
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !halt && !hold && !cnt_up && count != '0) |=> (count == $past(count) - 1'b1));

  // R5
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !halt && hold) |=> ($stable(count) && !wrap_pulse));

  // R6
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !wrap_pulse);

  // R9
  pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrap_pulse) |-> ($past(count) == TOP || $past(count) == '0));
endmodule

// File: tb/updn_hold_counter_tb.sv
module updn_hold_counter_tb;
  localparam int W = 4;
  localparam int MAXV = 15;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_up = 1'b1;
  logic         hold = 1'b0;
  logic         halt = 1'b0;
  logic [1:0]   src_sel = 2'd0;
  logic         reload_mode = 1'b0;
  logic [W-1:0] const_word = '0;
  logic [W-1:0] adc_word = '0;
  logic [W-1:0] spi_word = '0;
  logic [W-1:0] count;
  logic         wrap_pulse;

  int tests = 0;
  int fails = 0;
  int m_cnt = 0;
  bit m_pulse = 0;
  bit m_primed = 0;

  always #10 clk = ~clk;

  updn_hold_counter #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_up(cnt_up), .hold(hold), .halt(halt),
    .src_sel(src_sel), .reload_mode(reload_mode), .const_word(const_word),
    .adc_word(adc_word), .spi_word(spi_word), .count(count), .wrap_pulse(wrap_pulse)
  );

  function automatic int srcv();
    case (src_sel)
      2'd0: return int'(const_word);
      2'd1: return int'(adc_word);
      default: return int'(spi_word);
    endcase
  endfunction

  task automatic check(string tag);
    tests++;
    if (int'(count) != m_cnt) begin
      fails++;
      $display("FAIL %s count actual=%0d expected=%0d", tag, count, m_cnt);
    end
    tests++;
    if (wrap_pulse != m_pulse) begin
      fails++;
      $display("FAIL R9 pulse (%s) actual=%0b expected=%0b", tag, wrap_pulse, m_pulse);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    if (!m_primed || halt) begin
      m_cnt = srcv(); m_pulse = 0; m_primed = 1;
    end else if (hold) begin
      m_pulse = 0;
    end else if (cnt_up) begin
      if (m_cnt == MAXV) begin m_cnt = reload_mode ? srcv() : 0; m_pulse = 1; end
      else begin m_cnt = m_cnt + 1; m_pulse = 0; end
    end else begin
      if (m_cnt == 0) begin m_cnt = reload_mode ? srcv() : 0; m_pulse = 1; end
      else begin m_cnt = m_cnt - 1; m_pulse = 0; end
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    m_cnt = 0; m_pulse = 0;
    check("R1");
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v <= MAXV; v++) begin
        rst_n = 1'b0;
        m_primed = 0; m_cnt = 0; m_pulse = 0;
        @(negedge clk);
        check("R1");
        src_sel = 2'(s);
        const_word = 4'(v); adc_word = 4'(v + 5); spi_word = 4'(v + 9);
        reload_mode = v[0];
        cnt_up = 1'b1; hold = 1'b0; halt = 1'b0;
        rst_n = 1'b1;
        tick("R2");
        halt = 1'b1;
        tick("R2");
        halt = 1'b0;
        for (int i = 0; i < 22; i++) begin
          hold = (i % 7 == 3);
          if (i == 10) begin const_word = 4'(v + 3); adc_word = 4'(v + 7); spi_word = 4'(v + 11); end
          tick(hold ? "R5" : (m_cnt == MAXV ? "R7" : "R3"));
        end
        hold = 1'b0;
        cnt_up = 1'b0;
        reload_mode = ~reload_mode;
        for (int i = 0; i < 22; i++) begin
          hold = (i % 5 == 2);
          tick(hold ? "R5" : (m_cnt == 0 ? "R8" : "R4"));
        end
        hold = 1'b1; halt = 1'b1;
        tick("R6");
        hold = 1'b0; halt = 1'b0; cnt_up = 1'b1;
        tick("R6");
        tick("R6");
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule